// File: doc/BRIEF.md
# I2C Master Arbitration-Loss Detector

This block sits beside the byte engine of an I2C master and decides, bit by bit, whether the local node still owns a shared bus. While the node is in master-transmitter mode and a transfer is running, every rising SCL edge compares two levels: the level the node is driving on SDA and the level the bus actually shows. The bus is wired-AND, so another master that pulls SDA low while this node has released it wins the bus.

When the node loses, the block sets a sticky lost flag and clears both the master and transmitter role bits, which leaves the node in slave-receiver mode. It also releases SDA and stops passing clock pulses onto SCL. Until the surrounding byte engine reports the end of the current byte, a request to become master again is refused. Software clears the lost flag by accessing the data buffer or writing the control register.

The bus inputs pass through a synchroniser with a parameter-set number of stages before any edge detection or comparison. The clock generator, the shifter and the start/stop logic stay outside the block and feed it through plain inputs.

Top module: `i2c_arb_watch`

## Requirements
- R1: After reset, lost, master and transmitter status are 0, and both drive outputs are 1. A drive output of 1 means released and 0 means pulled low.
- R2: A one-cycle pulse on `go_master` sets master and transmitter to 1. While both are 1, `sda_drv` follows `tx_sda` and `scl_drv` follows `gen_scl`.
- R3: The comparison happens only on a rising edge of the synchronised SCL. A low SDA that appears while SCL stays high does not set the lost flag.
- R4: A bit driven as 0 never causes a loss, whatever the other masters drive.
- R5: The comparison is enabled only while master, transmitter and `xfer_act` are all 1. A mismatch seen while `xfer_act` is 0 is ignored.
- R6: If the node drives 1 at a rising SCL edge and the bus shows 0, the lost flag sets and master and transmitter both clear to 0. From then on `sda_drv` stays 1, whatever `tx_sda` is.
- R7: After a loss, `scl_drv` stays 1 whatever `gen_scl` does.
- R8: After a loss, `go_master` pulses are ignored until a `byte_end` pulse. Once that pulse has arrived, `go_master` works again.
- R9: The lost flag clears one cycle after a `buf_acc` pulse or a `ctl_wr` pulse. If a new loss happens in the same cycle as the clear, the loss wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level seen on the bus |
| sda_in | input | 1 | Raw SDA level seen on the bus |
| go_master | input | 1 | Request to enter master-transmitter mode |
| xfer_act | input | 1 | A transfer is in progress |
| tx_sda | input | 1 | Bit the shifter wants on SDA (1 = release) |
| gen_scl | input | 1 | SCL level from the clock generator |
| byte_end | input | 1 | End of the current byte |
| buf_acc | input | 1 | Data buffer read or write strobe |
| ctl_wr | input | 1 | Control register write strobe |
| sda_drv | output | 1 | Internal SDA drive (1 = released) |
| scl_drv | output | 1 | Internal SCL drive (1 = released) |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| mode_mst | output | 1 | Master role bit |
| mode_trx | output | 1 | Transmitter role bit |

## Verification
The bench builds the block with three synchroniser stages instead of the default two. This confirms that edge detection and the comparison follow the stage count and do not rely on a fixed latency. The bench models the bus as a wired-AND of the block's drive and a second master, so the bus levels come from the block's own outputs. With the longer synchroniser window, the checks show that a driven bit held stable across the window is compared correctly, and that a low SDA appearing while SCL stays high is not taken as a loss.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Registered state of the arbitration watcher
    typedef struct packed {
        logic lost;   // sticky arbitration-lost flag
        logic mst;    // master role
        logic trx;    // transmitter role
        logic hold;   // SDA held released for the rest of the byte
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{lost: 1'b0, mst: 1'b0, trx: 1'b0, hold: 1'b0};

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stg_d[g] = din;
        end else begin : g_next
            always_comb stg_d[g] = stg_q[g-1];
        end

        // Idle bus level is high, so every stage resets to 1
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '1;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/arb_edge.sv
module arb_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/arb_core.sv
module arb_core
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic sda_bus,
    input  logic go_master,
    input  logic xfer_act,
    input  logic tx_sda,
    input  logic gen_scl,
    input  logic byte_end,
    input  logic buf_acc,
    input  logic ctl_wr,
    output logic sda_drv,
    output logic scl_drv,
    output logic arb_lost,
    output logic mode_mst,
    output logic mode_trx
);
    arb_state_t st_d, st_q;
    logic       cmp_en;
    logic       loss_evt;

    always_comb begin
        sda_drv  = (st_q.mst && st_q.trx && !st_q.hold) ? tx_sda : 1'b1;
        scl_drv  = (st_q.mst && !st_q.hold) ? gen_scl : 1'b1;
        cmp_en   = st_q.mst && st_q.trx && xfer_act;
        // Only a released bit can be overridden on a wired-AND bus
        loss_evt = scl_rise && cmp_en && sda_drv && !sda_bus;

        st_d = st_q;
        if (byte_end) st_d.hold = 1'b0;
        if (go_master && !st_q.hold) begin
            st_d.mst = 1'b1;
            st_d.trx = 1'b1;
        end
        if (buf_acc || ctl_wr) st_d.lost = 1'b0;
        if (loss_evt) begin
            st_d.lost = 1'b1;
            st_d.mst  = 1'b0;
            st_d.trx  = 1'b0;
            st_d.hold = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARB_RESET;
        else        st_q <= st_d;
    end

    assign arb_lost = st_q.lost;
    assign mode_mst = st_q.mst;
    assign mode_trx = st_q.trx;

    // R6: a new loss always leaves slave-receiver mode with SDA released
    a_r6_roles_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lost) |-> (!mode_mst && !mode_trx && sda_drv));

    // R7: clock output released once the loss is registered
    a_r7_scl_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lost) |-> scl_drv);

    // R4: a driven low bit at an edge never produces a loss
    a_r4_low_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && !sda_drv) |=> !$rose(st_q.lost));

    // R5: no loss outside master-transmitter with an active transfer
    a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_mst && mode_trx && xfer_act) |=> !$rose(st_q.lost));

    // R8: a request during hold does not restore master role
    a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && go_master && !loss_evt) |=> !mode_mst);

    // R9: clear strobe without a simultaneous loss drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_acc || ctl_wr) && !loss_evt) |=> !arb_lost);

endmodule

// File: rtl/i2c_arb_watch.sv
module i2c_arb_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic go_master,
    input  logic xfer_act,
    input  logic tx_sda,
    input  logic gen_scl,
    input  logic byte_end,
    input  logic buf_acc,
    input  logic ctl_wr,
    output logic sda_drv,
    output logic scl_drv,
    output logic arb_lost,
    output logic mode_mst,
    output logic mode_trx
);
    localparam int BUS_W = 2;

    logic [BUS_W-1:0] bus_raw, bus_syn;
    logic             scl_rise;

    assign bus_raw = {scl_in, sda_in};

    arb_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_raw),
        .dout (bus_syn)
    );

    arb_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (bus_syn[1]),
        .rise (scl_rise)
    );

    arb_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .sda_bus  (bus_syn[0]),
        .go_master(go_master),
        .xfer_act (xfer_act),
        .tx_sda   (tx_sda),
        .gen_scl  (gen_scl),
        .byte_end (byte_end),
        .buf_acc  (buf_acc),
        .ctl_wr   (ctl_wr),
        .sda_drv  (sda_drv),
        .scl_drv  (scl_drv),
        .arb_lost (arb_lost),
        .mode_mst (mode_mst),
        .mode_trx (mode_trx)
    );

endmodule

// File: tb/i2c_arb_watch_bench.sv
module i2c_arb_watch_bench;
    localparam int P_SYNC = 3;
    localparam int SETTLE = P_SYNC + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go_master = 1'b0, xfer_act = 1'b1, tx_sda = 1'b1, gen_scl = 1'b1;
    logic byte_end = 1'b0, buf_acc = 1'b0, ctl_wr = 1'b0;
    logic oth_sda = 1'b1, oth_scl = 1'b1;
    logic sda_drv, scl_drv, arb_lost, mode_mst, mode_trx;
    logic sda_bus, scl_bus;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Wired-AND bus between this node and a second master
    assign sda_bus = sda_drv & oth_sda;
    assign scl_bus = scl_drv & oth_scl;

    i2c_arb_watch #(.SYNC_STAGES(P_SYNC)) u_i2c_arb_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .go_master(go_master), .xfer_act(xfer_act), .tx_sda(tx_sda),
        .gen_scl(gen_scl), .byte_end(byte_end), .buf_acc(buf_acc),
        .ctl_wr(ctl_wr), .sda_drv(sda_drv), .scl_drv(scl_drv),
        .arb_lost(arb_lost), .mode_mst(mode_mst), .mode_trx(mode_trx)
    );

    // Expected {lost, mst, trx, sda_drv, scl_drv}
    typedef struct {
        string      tag;
        logic [4:0] v;
    } exp_t;
    exp_t sb_q[$];

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_st(string tag, logic [4:0] v);
        exp_t e;
        e.tag = tag;
        e.v   = v;
        sb_q.push_back(e);
        tick(2);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        tick(1);
        s = 1'b0;
        tick(SETTLE);
    endtask

    task automatic clk_bit(logic tx, logic oth);
        gen_scl = 1'b0;
        tick(SETTLE);
        tx_sda  = tx;
        oth_sda = oth;
        tick(SETTLE);
        gen_scl = 1'b1;
        tick(SETTLE);
    endtask

    // Monitor: compares queued expectations against the ports
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [4:0] act;
            e   = sb_q.pop_front();
            act = {arb_lost, mode_mst, mode_trx, sda_drv, scl_drv};
            n_run++;
            if (act !== e.v) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b", e.tag, act, e.v);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_st("R1 reset state", 5'b00011);
        rst_n = 1'b1;
        tick(SETTLE);

        pulse(go_master);
        expect_st("R2 master-transmitter entered", 5'b01111);

        clk_bit(1'b0, 1'b1);
        expect_st("R4 driven low bit is safe", 5'b01101);

        clk_bit(1'b1, 1'b1);
        expect_st("R3 matching released bit", 5'b01111);

        oth_sda = 1'b0;
        tick(SETTLE);
        expect_st("R3 SDA low with SCL steady high", 5'b01111);
        oth_sda = 1'b1;
        tick(SETTLE);

        xfer_act = 1'b0;
        clk_bit(1'b1, 1'b0);
        expect_st("R5 mismatch with no transfer", 5'b01111);

        xfer_act = 1'b1;
        clk_bit(1'b1, 1'b0);
        expect_st("R6 loss detected", 5'b10011);

        tx_sda = 1'b0;
        tick(SETTLE);
        expect_st("R6 SDA held released", 5'b10011);

        gen_scl = 1'b0;
        tick(SETTLE);
        expect_st("R7 SCL stays released", 5'b10011);

        pulse(go_master);
        expect_st("R8 request refused during hold", 5'b10011);

        pulse(buf_acc);
        expect_st("R9 buffer access clears flag", 5'b00011);

        tx_sda = 1'b1;
        pulse(byte_end);
        pulse(go_master);
        expect_st("R8 request accepted after byte end", 5'b01110);

        clk_bit(1'b1, 1'b0);
        expect_st("R6 second loss", 5'b10011);

        pulse(ctl_wr);
        expect_st("R9 control write clears flag", 5'b00011);

        oth_sda = 1'b1;
        pulse(byte_end);
        pulse(go_master);
        clk_bit(1'b1, 1'b1);
        expect_st("R2 resumed transmit", 5'b01111);

        while (sb_q.size() > 0) tick(1);
        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule